// File: doc/BRIEF.md
# Buffer-Threshold Frequency Level Controller

This block picks the operating frequency of one router's clock domain from how full that router's input buffers are. Every router carries its own copy, which runs on its own. The router reports its total buffered flit count, and the controller maps that count onto one of three frequency levels: slow (250 MHz), medium (500 MHz) and fast (800 MHz). A nearly empty router is slowed down, and a congested one is sped up.

The buffer count is not tracked every cycle. A programmable interval timer sets when the count is sampled. At the end of each interval the count is placed in one of three bands, and the level state machine moves to that band's state. When the new level differs from the old one, a one-cycle strobe tells the downstream clock generator to retune. An enable input freezes both the level and the timer.

The level state machine has three states, each named after the level it drives: `FL_SLOW`, `FL_MID` and `FL_FAST`. Reset enters `FL_FAST`. On an evaluation tick, any state moves to the state of the sampled band. The transitions are named go-slow, go-mid and go-fast, and a transition into the state already held counts as a stay. With no tick, the machine stays where it is.

Top module: `freq_level_ctrl`

## Requirements
- R1: The level output is a 2-bit code where 0 means 250 MHz, 1 means 500 MHz and 2 means 800 MHz. Code 3 never appears.
- R2: An evaluation whose sampled fill is below the low threshold (default 10 flits) selects code 0.
- R3: An evaluation whose sampled fill is at least the low threshold and below the high threshold (default 20 flits) selects code 1.
- R4: An evaluation whose sampled fill is at least the high threshold selects code 2.
- R5: During and after reset, the level is 2 and the strobe is low until the first evaluation.
- R6: With interval N ≥ 1, the first evaluation samples the fill on the Nth enabled clock edge, counted from the edge where enable is first seen high. Evaluations then repeat every N edges. The new level is visible right after the sampling edge, and the level does not change between evaluations.
- R7: An interval value of 0 behaves like 1, so an evaluation happens on every enabled edge.
- R8: Whenever the level changes, the strobe is high in exactly the cycle that first shows the new level.
- R9: The strobe is never high unless the level has just changed. An evaluation that lands in the current band gives no strobe.
- R10: While enable is low, the level holds and no strobe is produced. On re-enable, the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the policy. Low freezes the level and clears the timer |
| interval | input | CNT_W (16) | Evaluation interval in cycles (0 is treated as 1) |
| buf_fill | input | FILL_W (8) | Total buffered flits in the router |
| level | output | 2 | Frequency level code |
| level_change | output | 1 | One-cycle retune strobe |

## Verification
The band mapping is tested with a sequence of fill values on a one-cycle interval. The sequence hits both sides of each threshold (9/10, 19/20), the extremes 0 and 255, and jumps that skip the middle band in both directions. This separates off-by-one threshold faults from wrong band ordering. Repeated fills inside the same band separate a correct strobe from one that fires on every evaluation. Longer intervals are used to tell a correct evaluation period from an early or late sample, and interval 0 shows that the zero case is clamped rather than wrapping to a huge count. A fill change made while enable is low tells a true freeze apart from a level that tracks the input anyway.

// File: rtl/freq_level_pkg.sv
package freq_level_pkg;

    // Frequency level codes; the numeric value is what the clock generator decodes.
    typedef enum logic [1:0] {
        FL_SLOW = 2'd0,   // 250 MHz
        FL_MID  = 2'd1,   // 500 MHz
        FL_FAST = 2'd2    // 800 MHz
    } freq_lvl_e;

endpackage

// File: rtl/fl_interval_timer.sv
module fl_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] interval,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Interval 0 is clamped to one cycle.
    always_comb begin
        if (interval == '0) begin
            limit = '0;
        end else begin
            limit = interval - CNT_W'(1);
        end
    end

    // >= guards against the interval shrinking below the running count.
    assign tick = enable && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fl_band_classifier.sv
module fl_band_classifier
    import freq_level_pkg::*;
#(
    parameter int FILL_W   = 8,
    parameter int LOW_THR  = 10,
    parameter int HIGH_THR = 20
) (
    input  logic [FILL_W-1:0] fill,
    output freq_lvl_e         band
);

    localparam logic [FILL_W-1:0] LOW_L  = FILL_W'(LOW_THR);
    localparam logic [FILL_W-1:0] HIGH_L = FILL_W'(HIGH_THR);

    always_comb begin
        if (fill >= HIGH_L) begin
            band = FL_FAST;
        end else if (fill >= LOW_L) begin
            band = FL_MID;
        end else begin
            band = FL_SLOW;
        end
    end

endmodule

// File: rtl/fl_level_fsm.sv
module fl_level_fsm
    import freq_level_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  freq_lvl_e band,
    output freq_lvl_e state,
    output logic      change
);

    freq_lvl_e state_q;
    freq_lvl_e state_d;
    logic      change_q;

    // Next-state logic: on a tick, go to the sampled band's state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_SLOW: if (tick) state_d = band;   // stay, go-mid, go-fast
            FL_MID:  if (tick) state_d = band;   // go-slow, stay, go-fast
            FL_FAST: if (tick) state_d = band;   // go-slow, go-mid, stay
            default: state_d = FL_FAST;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FL_FAST;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: strobe goes high together with the new level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            change_q <= 1'b0;
        end else begin
            change_q <= (state_d != state_q);
        end
    end

    assign state  = state_q;
    assign change = change_q;

endmodule

// File: rtl/freq_level_ctrl.sv
module freq_level_ctrl
    import freq_level_pkg::*;
#(
    parameter int FILL_W   = 8,
    parameter int CNT_W    = 16,
    parameter int LOW_THR  = 10,
    parameter int HIGH_THR = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  interval,
    input  logic [FILL_W-1:0] buf_fill,
    output logic [1:0]        level,
    output logic              level_change
);

    logic      tick;
    freq_lvl_e band;
    freq_lvl_e state;

    fl_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .interval (interval),
        .tick     (tick)
    );

    fl_band_classifier #(
        .FILL_W   (FILL_W),
        .LOW_THR  (LOW_THR),
        .HIGH_THR (HIGH_THR)
    ) u_class (
        .fill (buf_fill),
        .band (band)
    );

    fl_level_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .band   (band),
        .state  (state),
        .change (level_change)
    );

    assign level = state;

endmodule

// File: rtl/freq_level_ctrl_chk.sv
module freq_level_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [1:0] level,
    input logic       level_change
);

    assert_code_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level != 2'd3);

    assert_strobe_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> level_change);

    assert_no_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        level_change |-> (level != $past(level)));

    assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(level) && !level_change));

endmodule

bind freq_level_ctrl freq_level_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .level        (level),
    .level_change (level_change)
);

// File: tb/freq_level_ctrl_bench.sv
`timescale 1ns/1ps
module freq_level_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] interval = 16'd1;
    logic [7:0]  buf_fill = 8'd0;
    logic [1:0]  level;
    logic        level_change;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    freq_level_ctrl u_freq_level_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .interval     (interval),
        .buf_fill     (buf_fill),
        .level        (level),
        .level_change (level_change)
    );

    localparam int NV = 12;
    localparam logic [7:0] V_FILL [NV] = '{8'd0, 8'd9, 8'd10, 8'd19, 8'd20, 8'd255,
                                           8'd5, 8'd15, 8'd25, 8'd12, 8'd3, 8'd21};
    localparam logic [1:0] V_LVL  [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2,
                                           2'd0, 2'd1, 2'd2, 2'd1, 2'd0, 2'd2};

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [1:0] prev;
        // R5: reset state
        repeat (3) @(negedge clk);
        check("R5 level in reset", level, 2);
        check("R5 strobe in reset", level_change, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 level after reset, disabled", level, 2);
        check("R5 strobe after reset", level_change, 0);

        // Table: interval 1, one evaluation per edge (R1-R4, R8, R9)
        interval = 16'd1;
        enable = 1'b1;
        prev = 2'd2;
        for (int i = 0; i < NV; i++) begin
            buf_fill = V_FILL[i];
            @(negedge clk);
            check("R2/R3/R4 band level", level, V_LVL[i]);
            check("R8/R9 strobe", level_change, (V_LVL[i] != prev) ? 1 : 0);
            check("R1 legal code", (level != 2'd3) ? 1 : 0, 1);
            prev = V_LVL[i];
        end
        // level now 2

        // R10: disabled, input change ignored
        enable = 1'b0;
        buf_fill = 8'd2;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R10 held level", level, 2);
            check("R10 no strobe", level_change, 0);
        end

        // R6: interval 5 from re-enable, fill 2 selects slow on the 5th edge
        interval = 16'd5;
        enable = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R6 level timing", level, (k < 5) ? 2 : 0);
            check("R6 strobe timing", level_change, (k < 5) ? 0 : 1);
        end
        // R6: next evaluation 5 edges later, fill 15 selects mid
        buf_fill = 8'd15;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R6 second period level", level, (k < 5) ? 0 : 1);
            check("R8 second period strobe", level_change, (k < 5) ? 0 : 1);
        end
        // R9: same band again, no strobe
        buf_fill = 8'd18;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R9 same band no strobe", level_change, 0);
            check("R9 same band level", level, 1);
        end

        // R10: re-enable restarts count (disable mid-interval)
        buf_fill = 8'd30;
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R10 restart level", level, (k < 5) ? 1 : 2);
        end

        // R7: interval 0 acts as 1
        interval = 16'd0;
        buf_fill = 8'd1;
        @(negedge clk);
        check("R7 zero interval level", level, 0);
        check("R7 zero interval strobe", level_change, 1);
        buf_fill = 8'd11;
        @(negedge clk);
        check("R7 zero interval next edge", level, 1);
        @(negedge clk);
        check("R8 strobe lasts one cycle", level_change, 0);

        // R5: reset mid-run returns to fast
        rst_n = 1'b0;
        @(negedge clk);
        check("R5 reset reload", level, 2);
        check("R5 reset strobe", level_change, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule